// File: doc/BRIEF.md
# Clause-22 PHY Management Frame Master

This block drives the two-wire serial management bus that a MAC uses to read and write the 16-bit registers of an Ethernet PHY. A single-cycle request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete management frame on its own, with `busy` held high for the whole frame. It optionally starts with a run of 32 ones for synchronisation. At the end it raises a one-cycle `done`.

The management clock is made by dividing the system clock. A parameter gives the system clock frequency, and the divider holds each half of the management clock for enough cycles to stay at or below 2.5 MHz. The data line is modelled as three wires: an output value, an output enable, and an input. A read returns the 16-bit register value. The block also reports when that value looks like an empty address, meaning all zeros or all ones.

Top module: `mdio_frame_master`

## Requirements
- R1: `mdc` idles low. While a frame runs, each high phase and each low phase of `mdc` lasts exactly ceil(CLK_HZ / (2 * MDC_MAX_HZ)) system clock cycles. With the defaults this is 50 cycles.
- R2: When `pre_en` is 1 at the request, 32 one bits are driven before the command. When `pre_en` is 0, no such bits are sent.
- R3: A read drives 16 command bits, MSB first, with `mdio_oe` high. The bits are 1,1, then 0,1, then 1,0, then the PHY address bits 4..0, then the register address bits 4..0. As a number this is 0xD800 | phy<<5 | reg.
- R4: A write drives 32 bits, MSB first. The bits are 0,1, then 0,1, then the PHY address bits 4..0, then the register address bits 4..0, then 1,0, then the data bits 15..0. As a number this is 0x50020000 | phy<<23 | reg<<18 | data.
- R5: After the read command, `mdio_oe` stays low for exactly 20 rising edges of `mdc`. `mdio_i` is sampled before each of these edges, and sample k (k = 0 is first) goes to bit 19-k of a 20-bit capture. The read result is bits 16..1 of that capture.
- R6: After a write frame, `mdio_oe` stays low for exactly 2 more rising edges of `mdc`.
- R7: `mdio_o` and `mdio_oe` change only while `mdc` is low. They are stable in every cycle where `mdc` is high.
- R8: `busy` rises in the cycle after an accepted request and stays high until the frame ends. A request made while `busy` is high is ignored and starts no frame.
- R9: `done` is high for exactly one cycle, in the first cycle after the frame with `busy` low. `rd_data` changes only when a read completes and is held otherwise, including across writes.
- R10: `no_phy` is updated at each read completion. It is 1 if the result is 0x0000 or 0xFFFF and 0 otherwise. Writes leave it unchanged.
- R11: After reset, `mdc`, `mdio_oe`, `busy`, `done`, `no_phy` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a frame (taken only when idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| pre_en | input | 1 | Send 32-bit preamble before the frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Result of the last read |
| no_phy | output | 1 | Last read returned all zeros or all ones |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench models the PHY side of the bus. It records every bit the master drives on a rising `mdc` edge and feeds read bits back from a 20-bit pattern. The pattern places a value opposite to the data MSB just ahead of the data, so a capture that is shifted by one position gives a wrong result. Reads are swept over the all-zero, all-one and single-bit-set addresses, and over data values 0x0000, 0xFFFF and walking or mixed patterns. These cases separate the `no_phy` extremes from normal results and expose address bits that are swapped or misplaced. Writes use matching address and data corners, with the preamble switched on and off in turn, so a missing preamble or extra idle clocks show up in the driven-bit counts. A request made in the middle of a frame checks that the frame runs on unchanged and that no second frame follows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_CMD, ST_TAIL} mdio_state_e;

  localparam int PRE_BITS     = 32;
  localparam int RD_CMD_BITS  = 16;
  localparam int WR_BITS      = 32;
  localparam int RD_TAIL_BITS = 20;
  localparam int WR_TAIL_BITS = 2;

  // cycles per MDC half period, rounded up so MDC never runs fast
  function automatic int mdc_half(input longint clk_hz, input longint max_hz);
    longint h;
    h = (clk_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (h < 1) ? 1 : int'(h);
  endfunction

  // read command: two extra ones, start, read opcode, addresses
  function automatic logic [15:0] rd_cmd(input logic [4:0] phy, input logic [4:0] rg);
    return {2'b11, 2'b01, 2'b10, phy, rg};
  endfunction

  // write word: start, write opcode, addresses, turnaround, data
  function automatic logic [31:0] wr_word(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [15:0] d);
    return {2'b01, 2'b01, phy, rg, 2'b10, d};
  endfunction

  // drop the final idle sample and the leading turnaround samples
  function automatic logic [15:0] rd_extract(input logic [19:0] cap);
    return cap[16:1];
  endfunction

  function automatic logic looks_absent(input logic [15:0] d);
    return (d == 16'h0000) || (d == 16'hFFFF);
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic tick;

  generate
    if (HALF < 2) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !run) mdc <= 1'b0;
    else if (tick)      mdc <= ~mdc;
  end

  assign rise_ev = tick & ~mdc;
  assign fall_ev = tick & mdc;
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        pre_en,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        no_phy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_end
);
  localparam int BW = $clog2(PRE_BITS + 1);

  mdio_state_e    state;
  logic [31:0]    shreg;
  logic [BW-1:0]  bits_left;
  logic           is_rd;
  logic [19:0]    cap;
  logic           last_bit;

  assign busy      = (state != ST_IDLE);
  assign last_bit  = (bits_left == BW'(1));
  assign frame_end = fall_ev && (state == ST_TAIL) && last_bit;
  assign mdio_oe   = (state == ST_PRE) || (state == ST_CMD);
  assign mdio_o    = (state == ST_PRE) ? 1'b1 : ((state == ST_CMD) ? shreg[31] : 1'b0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      is_rd     <= 1'b0;
      cap       <= '0;
      rd_data   <= '0;
      no_phy    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (req) begin
          is_rd     <= req_rd;
          shreg     <= req_rd ? {rd_cmd(req_phy, req_reg), 16'h0000}
                              : wr_word(req_phy, req_reg, req_wdata);
          state     <= pre_en ? ST_PRE : ST_CMD;
          bits_left <= pre_en ? BW'(PRE_BITS) : (req_rd ? BW'(RD_CMD_BITS) : BW'(WR_BITS));
        end
      end else begin
        if (rise_ev && state == ST_TAIL && is_rd)
          cap <= {cap[18:0], mdio_i};
        if (fall_ev) begin
          case (state)
            ST_PRE: begin
              if (last_bit) begin
                state     <= ST_CMD;
                bits_left <= is_rd ? BW'(RD_CMD_BITS) : BW'(WR_BITS);
              end else bits_left <= bits_left - 1'b1;
            end
            ST_CMD: begin
              shreg <= {shreg[30:0], 1'b0};
              if (last_bit) begin
                state     <= ST_TAIL;
                bits_left <= is_rd ? BW'(RD_TAIL_BITS) : BW'(WR_TAIL_BITS);
                cap       <= '0;
              end else bits_left <= bits_left - 1'b1;
            end
            ST_TAIL: begin
              if (last_bit) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                if (is_rd) begin
                  rd_data <= rd_extract(cap);
                  no_phy  <= looks_absent(rd_extract(cap));
                end
              end else bits_left <= bits_left - 1'b1;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter longint CLK_HZ     = 250_000_000,
  parameter longint MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        pre_en,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        no_phy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF_CYC = mdc_half(CLK_HZ, MDC_MAX_HZ);

  logic rise_ev;
  logic fall_ev;
  logic frame_end;

  mdio_mdc_gen #(.HALF(HALF_CYC)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .pre_en(pre_en), .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_data(rd_data), .no_phy(no_phy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_end(frame_end)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        frame_end,
  input logic [15:0] rd_data
);
  logic mdc_d;
  int   run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d   <= 1'b0;
      run_len <= 0;
    end else begin
      mdc_d <= mdc;
      if (!busy)             run_len <= 0;
      else if (mdc != mdc_d) run_len <= 1;
      else                   run_len <= run_len + 1;
    end
  end

  // R1
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len <= HALF + 1));

  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);

  // R7
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R8
  req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rd_data));
endmodule

bind mdio_frame_master mdio_master_chk #(.HALF(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_end(frame_end),
  .rd_data(rd_data)
);

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
  localparam longint CLK_HZ = 250_000_000;
  localparam longint MAX_HZ = 2_500_000;
  localparam int HALF = int'((CLK_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_rd = 1'b0, pre_en = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, no_phy, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mdio_frame_master #(.CLK_HZ(CLK_HZ), .MDC_MAX_HZ(MAX_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .pre_en(pre_en), .busy(busy),
    .done(done), .rd_data(rd_data), .no_phy(no_phy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  logic drv_bits [0:4095];
  int drv_n = 0, tail_n = 0, base_t = 0;
  logic [19:0] pat = '1;
  int bad_runs = 0, runs_seen = 0, run = 0;
  logic busy_d = 1'b0, mdc_d = 1'b0;
  longint cyc = 0;

  // PHY side: record driven bits, count released edges
  always @(posedge mdc) begin
    if (mdio_oe) begin drv_bits[drv_n] = mdio_o; drv_n++; end
    else tail_n++;
  end

  always_comb begin
    int k;
    k = tail_n - base_t;
    mdio_i = (k >= 0 && k < 20) ? pat[19 - k] : 1'b1;
  end

  // MDC run-length monitor
  always @(negedge clk) begin
    if (busy) begin
      if (!busy_d) run = 1;
      else if (mdc == mdc_d) run++;
      else begin
        if (run != HALF) bad_runs++;
        runs_seen++;
        run = 1;
      end
    end
    busy_d = busy;
    mdc_d = mdc;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic xfer(input bit rd, input bit pre, input logic [4:0] pa,
                      input logic [4:0] ra, input logic [15:0] d, input bit poke);
    int bd, bt, n, npre, ncmd, errs, drv_after;
    logic [31:0] word;
    logic [15:0] prev_rd;
    logic prev_np, exp_np;
    prev_rd = rd_data;
    prev_np = no_phy;
    @(negedge clk);
    pat = {1'b1, 1'b0, ~d[15], d, 1'b1};
    bd = drv_n;
    bt = tail_n;
    base_t = tail_n;
    req = 1'b1; req_rd = rd; req_phy = pa; req_reg = ra; req_wdata = d; pre_en = pre;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R8 busy after request", busy, 1);
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 700) begin
        req = 1'b1; req_rd = ~rd; req_phy = ~pa; pre_en = ~pre;
      end else req = 1'b0;
    end
    chk(busy == 1'b0, "R9 busy low with done", busy, 0);
    npre = pre ? 32 : 0;
    ncmd = rd ? 16 : 32;
    word = rd ? ((32'h0000D800 | (32'(pa) << 5) | 32'(ra)) << 16)
              : (32'h50020000 | (32'(pa) << 23) | (32'(ra) << 18) | 32'(d));
    chk(drv_n - bd == npre + ncmd, rd ? "R3 driven bit count" : "R4 driven bit count",
        drv_n - bd, npre + ncmd);
    errs = 0;
    for (int i = 0; i < npre; i++) if (drv_bits[bd + i] !== 1'b1) errs++;
    chk(errs == 0, "R2 preamble ones", errs, 0);
    errs = 0;
    for (int i = 0; i < ncmd; i++) if (drv_bits[bd + npre + i] !== word[31 - i]) errs++;
    chk(errs == 0, rd ? "R3 read command bits" : "R4 write frame bits", errs, 0);
    chk(tail_n - bt == (rd ? 20 : 2), rd ? "R5 released edges" : "R6 released edges",
        tail_n - bt, rd ? 20 : 2);
    if (rd) begin
      chk(rd_data == 16'((pat >> 1) & 20'hFFFF), "R5 read data", rd_data, d);
      exp_np = (d == 16'h0000) || (d == 16'hFFFF);
      chk(no_phy == exp_np, "R10 no_phy after read", no_phy, exp_np);
    end else begin
      chk(rd_data == prev_rd, "R9 rd_data held over write", rd_data, prev_rd);
      chk(no_phy == prev_np, "R10 no_phy held over write", no_phy, prev_np);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    if (poke) begin
      drv_after = drv_n;
      repeat (300) @(negedge clk);
      chk(busy == 1'b0 && drv_n == drv_after, "R8 request during frame ignored",
          drv_n - drv_after, 0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0, "R11 reset controls",
        {mdc, mdio_oe, busy, done}, 0);
    chk(rd_data == 0 && no_phy == 0, "R11 reset data", {no_phy, rd_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdc == 0, "R1 idle low", mdc, 0);
    xfer(1, 1, 5'd1,  5'd1,  16'hA5C3, 0);
    xfer(0, 0, 5'd2,  5'd4,  16'h01E1, 0);
    xfer(1, 0, 5'd0,  5'd0,  16'h0000, 0);
    xfer(0, 1, 5'd31, 5'd0,  16'hFFFF, 0);
    xfer(1, 1, 5'd31, 5'd31, 16'hFFFF, 0);
    xfer(0, 0, 5'd0,  5'd31, 16'h0000, 0);
    xfer(1, 0, 5'd16, 5'd2,  16'h8000, 1);
    xfer(0, 1, 5'd21, 5'd10, 16'h5AA5, 0);
    xfer(1, 1, 5'd5,  5'd21, 16'h0001, 0);
    xfer(0, 0, 5'd7,  5'd30, 16'h8001, 1);
    xfer(1, 0, 5'd10, 5'd9,  16'h3C96, 0);
    chk(bad_runs == 0 && runs_seen > 0, "R1 MDC half period", bad_runs, 0);
    repeat (4) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0, "R1 idle low after frames", {mdc, mdio_oe}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule